// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines the low-order bits of the branch address with a register that holds the outcomes of the most recently resolved branches. The combined value selects one entry in a table of saturating counters. A fetch stage presents a branch address and gets a taken or not-taken guess back in the same cycle. The predictor also shows the history value it used for that guess, so the pipeline can carry it along with the branch.

When the branch resolves later, the pipeline sends back the branch address, the real outcome and the history value it carried. The block uses these to move the selected counter one step toward the real outcome. In the same clock edge it shifts the outcome into the global history register. Table entries carry no tags, so branches whose index bits match share one counter. If the history length is set to zero, the block becomes a plain table of counters indexed by address only.

Top module: `corr_dir_predictor`

## Requirements
- R1: After reset every counter holds 2^(CNT_W-1)-1 (weakly not taken) and the history register is zero. Every address then predicts not taken and `pred_hist` reads 0.
- R2: `pred_taken` is combinational from `pred_pc` and shows the current table state in the same cycle. It is 1 exactly when the selected counter is at least 2^(CNT_W-1).
- R3: The table index is {history, pc[ADDR_W+1:2]}, with the history in the upper bits. PC bits [1:0] and the bits above ADDR_W+1 do not affect the index.
- R4: On a clock edge with `upd_valid` high, the entry selected by `upd_hist` and `upd_pc` goes up by one if `upd_taken` is 1 and down by one if it is 0. No other entry changes, and nothing changes when `upd_valid` is low.
- R5: Counters saturate. They stay at 2^CNT_W-1 when a taken outcome arrives and stay at 0 when a not-taken outcome arrives.
- R6: Each update shifts `upd_taken` into bit 0 of the history register, and older bits move up by one position. The history holds its value when no update happens. `pred_hist` shows the register.
- R7: The update index uses `upd_hist` from the resolve port and not the current history register. The counter write and the history shift happen on the same edge.
- R8: Entries have no tags. Two addresses with equal index bits read and train the same counter.
- R9: When a prediction and an update select the same entry in the same cycle, the prediction shows the counter value from before the update.
- R10: With HIST_W=0 the index is pc[ADDR_W+1:2] alone. In that case `upd_hist` is ignored and `pred_hist` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Direction guess for `pred_pc` |
| pred_hist | output | max(HIST_W,1) | History value used for the guess |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | max(HIST_W,1) | History captured when that branch was predicted |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The hardest cases to reach are the ones where the history used by an update differs from the live history register. These include updates that carry an old snapshot, and a prediction that reads the same entry the update writes in that cycle. The stimulus drives `upd_hist` on its own, separately from the register. It sends explicit stale snapshots, and it also sends same-cycle collisions in which the prediction address equals the update address and the update history equals the live history. A second instance built with no history runs on the same stimulus to cover the address-only variant.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
   // Branch addresses are word aligned; this many low bits carry no index information.
   localparam int ALIGN_BITS = 2;

   // Width of a history-carrying port: at least one bit even with no history.
   function automatic int hist_port_w(input int hist_len);
      return (hist_len > 0) ? hist_len : 1;
   endfunction
endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
   parameter int HIST_W = 2,
   parameter int HP_W   = corr_bp_pkg::hist_port_w(HIST_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            shift_bit,
   output logic [HP_W-1:0] hist_o
);
   generate
      if (HIST_W == 0) begin : g_none
         logic unused_hist_in;
         assign unused_hist_in = ^{clk, rst_n, shift_en, shift_bit};
         assign hist_o = '0;
      end else begin : g_shift
         logic [HIST_W-1:0] hist_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               hist_q <= '0;
            else if (shift_en)
               hist_q <= HIST_W'({hist_q, shift_bit});
         end
         assign hist_o = hist_q;

         // R6: newest outcome enters bit 0
         assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
            shift_en |=> hist_q[0] == $past(shift_bit));
         // R6: history holds without an update
         assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !shift_en |=> $stable(hist_q));
      end
   endgenerate
endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
   parameter int PC_W   = 32,
   parameter int ADDR_W = 4,
   parameter int HIST_W = 2,
   parameter int HP_W   = corr_bp_pkg::hist_port_w(HIST_W),
   parameter int IDX_W  = HIST_W + ADDR_W
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [HP_W-1:0]  hist,
   output logic [IDX_W-1:0] idx
);
   localparam int LO = corr_bp_pkg::ALIGN_BITS;
   localparam int HI = LO + ADDR_W - 1;

   logic [ADDR_W-1:0] addr_bits;
   logic unused_pc_bits;
   assign addr_bits      = pc[HI:LO];
   assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};

   generate
      if (HIST_W == 0) begin : g_addr_only
         logic unused_hist_bits;
         assign unused_hist_bits = ^hist;
         assign idx = addr_bits;
      end else begin : g_correlated
         assign idx = {hist[HIST_W-1:0], addr_bits};
      end
   endgenerate
endmodule

// File: rtl/cbp_counter_table.sv
module cbp_counter_table #(
   parameter int CNT_W = 2,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'((1 << (CNT_W - 1)) - 1);

   logic [CNT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= CNT_INIT;
      end else if (wr_en) begin
         if (wr_taken && (mem[wr_idx] != CNT_MAX))
            mem[wr_idx] <= mem[wr_idx] + CNT_W'(1);
         else if (!wr_taken && (mem[wr_idx] != '0))
            mem[wr_idx] <= mem[wr_idx] - CNT_W'(1);
      end
   end

   // Upper half of the counter range means taken: the MSB alone decides.
   assign rd_taken = mem[rd_idx][CNT_W-1];

   // R5: saturation at the top
   assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_taken && (mem[wr_idx] == CNT_MAX) |=> mem[$past(wr_idx)] == CNT_MAX);
   // R5: saturation at the bottom
   assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_taken && (mem[wr_idx] == '0) |=> mem[$past(wr_idx)] == '0);
   // R4: single-step increase
   assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_taken && (mem[wr_idx] != CNT_MAX)
      |=> mem[$past(wr_idx)] == $past(mem[wr_idx]) + CNT_W'(1));
   // R4: without an update the entry being read keeps its value
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> mem[$past(rd_idx)] == $past(mem[rd_idx]));
endmodule

// File: rtl/corr_dir_predictor.sv
module corr_dir_predictor #(
   parameter int PC_W   = 32,
   parameter int ADDR_W = 4,
   parameter int HIST_W = 2,
   parameter int CNT_W  = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [PC_W-1:0]                       pred_pc,
   output logic                                  pred_taken,
   output logic [((HIST_W > 0) ? HIST_W : 1)-1:0] pred_hist,
   input  logic                                  upd_valid,
   input  logic [PC_W-1:0]                       upd_pc,
   input  logic [((HIST_W > 0) ? HIST_W : 1)-1:0] upd_hist,
   input  logic                                  upd_taken
);
   localparam int HP_W  = corr_bp_pkg::hist_port_w(HIST_W);
   localparam int IDX_W = HIST_W + ADDR_W;

   initial begin
      assert (ADDR_W >= 1);
      assert (CNT_W >= 1);
      assert (HIST_W >= 0);
      assert (PC_W > ADDR_W + corr_bp_pkg::ALIGN_BITS);
   end

   logic [HP_W-1:0]  hist_now;
   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;

   cbp_history #(.HIST_W(HIST_W), .HP_W(HP_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .shift_bit(upd_taken),
      .hist_o   (hist_now)
   );

   cbp_index #(.PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .HP_W(HP_W), .IDX_W(IDX_W)) u_rd_index (
      .pc  (pred_pc),
      .hist(hist_now),
      .idx (rd_idx)
   );

   cbp_index #(.PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .HP_W(HP_W), .IDX_W(IDX_W)) u_wr_index (
      .pc  (upd_pc),
      .hist(upd_hist),
      .idx (wr_idx)
   );

   cbp_counter_table #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rd_idx),
      .rd_taken(pred_taken),
      .wr_en   (upd_valid),
      .wr_idx  (wr_idx),
      .wr_taken(upd_taken)
   );

   assign pred_hist = hist_now;
endmodule

// File: tb/sim_corr_dir_predictor.sv
module sim_corr_dir_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic [31:0] upd_pc = '0;
   logic        upd_valid = 1'b0;
   logic        upd_taken = 1'b0;
   logic [1:0]  upd_hist = '0;
   logic        pred_taken, pred_taken1;
   logic [1:0]  pred_hist;
   logic [0:0]  pred_hist1;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   corr_dir_predictor u0 (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_hist(upd_hist), .upd_taken(upd_taken));

   // R10: address-only variant on the same stimulus
   corr_dir_predictor #(.HIST_W(0)) u1 (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken1),
      .pred_hist(pred_hist1), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_hist(upd_hist[0]), .upd_taken(upd_taken));

   // reference model
   logic [1:0] m0 [64];
   logic [1:0] m1 [16];
   logic [1:0] hist_m;

   // scoreboard queues
   bit         q_t[$];
   logic [1:0] q_h[$];
   bit         q_t1[$];
   string      q_r[$];

   function automatic int idx0(input logic [1:0] h, input logic [31:0] pc);
      return int'({h, pc[5:2]});
   endfunction

   function automatic logic [1:0] bump(input logic [1:0] c, input bit t);
      if (t && c != 2'd3) return c + 2'd1;
      if (!t && c != 2'd0) return c - 2'd1;
      return c;
   endfunction

   task automatic step(input logic [31:0] ppc, input bit uv, input logic [31:0] upc,
                       input logic [1:0] uh, input bit ut, input string req);
      @(negedge clk);
      pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut;
      q_t.push_back(m0[idx0(hist_m, ppc)][1]);
      q_h.push_back(hist_m);
      q_t1.push_back(m1[ppc[5:2]][1]);
      q_r.push_back(req);
      if (uv) begin
         m0[idx0(uh, upc)] = bump(m0[idx0(uh, upc)], ut);
         m1[upc[5:2]]      = bump(m1[upc[5:2]], ut);
         hist_m            = {hist_m[0], ut};
      end
   endtask

   // monitor: samples mid-cycle, well before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         while (q_t.size() > 0) begin
            bit et, et1; logic [1:0] eh; string r;
            et = q_t.pop_front(); eh = q_h.pop_front(); et1 = q_t1.pop_front(); r = q_r.pop_front();
            tests += 3;
            if (pred_taken !== et) begin
               fails++; $display("FAIL %s: pred_taken=%0b expected %0b", r, pred_taken, et);
            end
            if (pred_hist !== eh) begin
               fails++; $display("FAIL %s: pred_hist=%0d expected %0d", r, pred_hist, eh);
            end
            if (pred_taken1 !== et1 || pred_hist1 !== 1'b0) begin
               fails++; $display("FAIL R10: pred_taken=%0b hist=%0b expected %0b hist=0", pred_taken1, pred_hist1, et1);
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run still active, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) m0[i] = 2'd1;
      for (int i = 0; i < 16; i++) m1[i] = 2'd1;
      hist_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(32'h100, 0, 0, 0, 0, "R1");
      step(32'h104, 0, 0, 0, 0, "R1");
      step(32'h03C, 0, 0, 0, 0, "R1");
      step(32'hFFC, 0, 0, 0, 0, "R1");
      // R4: training up on one entry
      for (int i = 0; i < 3; i++) step(32'h48, 1, 32'h48, 2'b00, 1, "R4");
      step(32'h48, 0, 0, 0, 0, "R4");
      // R6: history shifting and holding
      step(32'h0, 1, 32'h10, 2'b10, 0, "R6");
      step(32'h0, 0, 0, 0, 0, "R6");
      step(32'h0, 1, 32'h14, 2'b10, 1, "R6");
      step(32'h0, 0, 0, 0, 0, "R6");
      // R5: saturation at both ends
      for (int i = 0; i < 5; i++) step(32'h4C, 1, 32'h4C, 2'b11, 1, "R5");
      for (int i = 0; i < 5; i++) step(32'h4C, 1, 32'h4C, 2'b11, 0, "R5");
      step(32'h4C, 1, 32'h4C, 2'b11, 1, "R5");
      step(32'h4C, 0, 0, 0, 0, "R5");
      // R7: stale snapshot on the resolve port
      for (int i = 0; i < 3; i++) step(32'h58, 1, 32'h58, 2'b01, 1, "R7");
      step(32'h58, 1, 32'h20, 2'b00, 0, "R7");
      step(32'h58, 1, 32'h20, 2'b00, 1, "R7");
      step(32'h58, 0, 0, 0, 0, "R7");
      // R3 and R8: ignored address bits and aliasing
      for (int i = 0; i < 3; i++) step(32'h50, 1, 32'h50, hist_m, 1, "R8");
      step(32'h53, 0, 0, 0, 0, "R3");
      step(32'h90, 0, 0, 0, 0, "R8");
      step(32'h1050, 0, 0, 0, 0, "R3");
      step(32'h54, 0, 0, 0, 0, "R3");
      // R9: same-entry read and write in one cycle
      for (int i = 0; i < 6; i++) step(32'h60, 1, 32'h60, hist_m, (i < 4), "R9");
      step(32'h60, 0, 0, 0, 0, "R9");
      // R2: mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b;
         a = {25'd0, 5'($urandom_range(0, 31)), 2'b00};
         b = {25'd0, 5'($urandom_range(0, 31)), 2'b00};
         step(a, ($urandom_range(0, 3) != 0), b, hist_m, ($urandom_range(0, 2) != 0), "R2");
      end
      step(32'h0, 0, 0, 0, 0, "R2");
      repeat (3) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule